// File: doc/BRIEF.md
# Event-Aligned Index Pulse Shaper

This block converts an asynchronous reset request into a clean, active-high index pulse of guaranteed minimum width. A downstream counter uses the pulse to clear itself. The pulse is timed by an internal tick stream, not by the raw system clock. That stream runs at a fixed division of the clock, and it freezes whenever the event input sits at its configured pause level. A reset request that arrives while the event signal is paused therefore produces no pulse until the event signal leaves the pause level. The pulse then starts at a known tick offset from that moment.

A rising edge on the request input arms a one-shot. The one-shot waits a programmable number of ticks with its output low, then holds the output high for a programmable number of ticks, then returns low. Both counts are taken from configuration inputs when they are needed, and a count of zero behaves as one tick. A new edge during the low wait restarts the wait. An edge during the high phase is discarded. Both asynchronous inputs pass through two-flop synchronizers before any logic uses them.

Top module: `idx_pulse_shaper`

## Requirements
- R1: While `rst_n` is low, and in the cycles after it is released with no request edge, `index_o` is 0.
- R2: While the event input is not at the pause level, ticks occur once every `DIV` clock cycles. With no pause, `index_o` rises exactly `3 + L*DIV` clock edges after the request input goes high. It stays high for exactly `H*DIV` cycles, where L and H are the effective low and high counts.
- R3: While the synchronized event input equals the pause level, no ticks occur and the tick divider holds its value. The pulse is delayed, and `index_o` rises `L*DIV` edges after the first unpaused cycle that follows the trigger.
- R4: `pause_lvl_i` = 1 makes a high event input the pause state. `pause_lvl_i` = 0 makes a low event input the pause state.
- R5: The rising edge is taken from the request input after a two-flop synchronizer. One edge starts one pulse, and a request held high starts no further pulse.
- R6: After a trigger, `index_o` stays low for L ticks, where L is `low_ticks_i`, or 1 when `low_ticks_i` is 0.
- R7: The high phase lasts H ticks, where H is `high_ticks_i`, or 1 when `high_ticks_i` is 0. `index_o` rises and falls only on ticks.
- R8: A request edge during the low wait restarts the wait from the new edge. The tick divider is cleared at the same time.
- R9: A request edge while `index_o` is high is ignored. The pulse ends at its original time, and no further pulse follows.
- R10: After the high phase `index_o` returns to 0 and stays there until the next request edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Asynchronous reset request; rising edge triggers |
| event_i | input | 1 | Asynchronous event signal that gates the tick stream |
| pause_lvl_i | input | 1 | Event level at which ticks are paused |
| low_ticks_i | input | CW | Ticks of low wait before the pulse (0 means 1) |
| high_ticks_i | input | CW | Ticks of pulse high time (0 means 1) |
| index_o | output | 1 | Active-high index pulse |

## Verification
The assertions assume that the request and event inputs change only between clock edges. They also assume that the configuration inputs (`pause_lvl_i` and the two counts) stay constant from a trigger until the pulse has ended. The stimulus drives every input on the falling clock edge and changes the configuration only while the block is idle. The stimulus also keeps each request level for at least two cycles, so that the synchronizer sees every edge it is meant to see.

// File: rtl/idx_shaper_pkg.sv
package idx_shaper_pkg;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_DELAY = 2'd1,
        PH_HOLD  = 2'd2
    } phase_e;

endpackage

// File: rtl/idx_sync2.sv
module idx_sync2 #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = d_i;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign q_o = st_q.s2;

endmodule

// File: rtl/idx_tick_gen.sv
module idx_tick_gen #(
    parameter int DIV = 5,
    localparam int DW = (DIV > 1) ? $clog2(DIV) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_i,
    input  logic          clear_i,
    output logic          tick_o,
    output logic [DW-1:0] cnt_o
);

    localparam logic [DW-1:0] LAST = DW'(DIV - 1);

    typedef struct packed {
        logic [DW-1:0] cnt;
    } div_t;

    div_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clear_i) begin
            st_d.cnt = '0;
        end else if (run_i) begin
            if (st_q.cnt == LAST) st_d.cnt = '0;
            else                  st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tick_o = run_i && !clear_i && (st_q.cnt == LAST);
    assign cnt_o  = st_q.cnt;

endmodule

// File: rtl/idx_one_shot.sv
module idx_one_shot
    import idx_shaper_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fire_i,
    input  logic          tick_i,
    input  logic [CW-1:0] low_n_i,
    input  logic [CW-1:0] high_n_i,
    output logic          restart_o,
    output logic          pulse_o,
    output phase_e        phase_o
);

    typedef struct packed {
        phase_e        ph;
        logic [CW-1:0] cnt;
        logic          pulse;
    } shot_t;

    shot_t st_d, st_q;

    function automatic logic [CW-1:0] at_least_one(input logic [CW-1:0] v);
        return (v == '0) ? CW'(1) : v;
    endfunction

    always_comb begin
        st_d      = st_q;
        restart_o = 1'b0;
        case (st_q.ph)
            PH_IDLE: begin
                if (fire_i) begin
                    st_d.ph   = PH_DELAY;
                    st_d.cnt  = at_least_one(low_n_i);
                    restart_o = 1'b1;
                end
            end
            PH_DELAY: begin
                if (fire_i) begin
                    st_d.cnt  = at_least_one(low_n_i);
                    restart_o = 1'b1;
                end else if (tick_i) begin
                    if (st_q.cnt <= CW'(1)) begin
                        st_d.ph    = PH_HOLD;
                        st_d.cnt   = at_least_one(high_n_i);
                        st_d.pulse = 1'b1;
                    end else begin
                        st_d.cnt = st_q.cnt - 1'b1;
                    end
                end
            end
            PH_HOLD: begin
                if (tick_i) begin
                    if (st_q.cnt <= CW'(1)) begin
                        st_d.ph    = PH_IDLE;
                        st_d.cnt   = '0;
                        st_d.pulse = 1'b0;
                    end else begin
                        st_d.cnt = st_q.cnt - 1'b1;
                    end
                end
            end
            default: begin
                st_d.ph    = PH_IDLE;
                st_d.cnt   = '0;
                st_d.pulse = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ph    <= PH_IDLE;
            st_q.cnt   <= '0;
            st_q.pulse <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pulse_o = st_q.pulse;
    assign phase_o = st_q.ph;

endmodule

// File: rtl/idx_pulse_shaper.sv
module idx_pulse_shaper
    import idx_shaper_pkg::*;
#(
    parameter int DIV = 5,
    parameter int CW  = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_i,
    input  logic          event_i,
    input  logic          pause_lvl_i,
    input  logic [CW-1:0] low_ticks_i,
    input  logic [CW-1:0] high_ticks_i,
    output logic          index_o
);

    localparam int DIV_W = (DIV > 1) ? $clog2(DIV) : 1;

    typedef struct packed {
        logic req_prev;
    } edge_t;

    logic [1:0]       raw_in;
    logic [1:0]       sync_out;
    logic             req_s;
    logic             evt_s;
    logic             paused;
    logic             rise;
    logic             tick_w;
    logic             restart;
    logic [DIV_W-1:0] div_cnt;
    phase_e           phase;
    edge_t            ed_d, ed_q;

    assign raw_in = {event_i, req_i};

    idx_sync2 #(.W(2)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (raw_in),
        .q_o   (sync_out)
    );

    assign req_s  = sync_out[0];
    assign evt_s  = sync_out[1];
    assign paused = (evt_s == pause_lvl_i);

    always_comb begin
        ed_d          = ed_q;
        ed_d.req_prev = req_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ed_q <= '0;
        else        ed_q <= ed_d;
    end

    assign rise = req_s && !ed_q.req_prev;

    idx_tick_gen #(.DIV(DIV)) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_i   (!paused),
        .clear_i (restart),
        .tick_o  (tick_w),
        .cnt_o   (div_cnt)
    );

    idx_one_shot #(.CW(CW)) u_shot (
        .clk       (clk),
        .rst_n     (rst_n),
        .fire_i    (rise),
        .tick_i    (tick_w),
        .low_n_i   (low_ticks_i),
        .high_n_i  (high_ticks_i),
        .restart_o (restart),
        .pulse_o   (index_o),
        .phase_o   (phase)
    );

endmodule

// File: rtl/idx_pulse_shaper_chk.sv
module idx_pulse_shaper_chk #(
    parameter int DIV = 5,
    parameter int DW  = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          index_o,
    input logic          tick,
    input logic          paused,
    input logic          restart,
    input logic          rise,
    input logic [DW-1:0] div_cnt,
    input logic          ph_idle,
    input logic          ph_hold
);

    generate
        if (DIV > 1) begin : g_gap
            AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick); // R2
        end
    endgenerate

    AST_PAUSE_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        paused |-> !tick); // R3

    AST_PAUSE_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (paused && !restart) |=> $stable(div_cnt)); // R3

    AST_RISE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(index_o) |-> $past(tick)); // R6

    AST_FALL_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(index_o) |-> $past(tick)); // R7

    AST_PULSE_IS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        index_o == ph_hold); // R7

    AST_HOLD_IGNORES_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        (index_o && rise && !tick) |=> index_o); // R9

    AST_IDLE_NEEDS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_idle && !rise) |=> (ph_idle && !index_o)); // R10

endmodule

bind idx_pulse_shaper idx_pulse_shaper_chk #(
    .DIV (DIV),
    .DW  (DIV_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .index_o (index_o),
    .tick    (tick_w),
    .paused  (paused),
    .restart (restart),
    .rise    (rise),
    .div_cnt (div_cnt),
    .ph_idle (phase == idx_shaper_pkg::PH_IDLE),
    .ph_hold (phase == idx_shaper_pkg::PH_HOLD)
);

// File: tb/idx_pulse_shaper_tb.sv
module idx_pulse_shaper_tb;

    localparam int DIV = 4;
    localparam int CW  = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_i = 1'b0;
    logic          event_i = 1'b0;
    logic          pause_lvl_i = 1'b1;
    logic [CW-1:0] low_ticks_i = '0;
    logic [CW-1:0] high_ticks_i = '0;
    logic          index_o;

    int checks = 0;
    int errs   = 0;

    always #10 clk = ~clk;

    idx_pulse_shaper #(.DIV(DIV), .CW(CW)) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_i        (req_i),
        .event_i      (event_i),
        .pause_lvl_i  (pause_lvl_i),
        .low_ticks_i  (low_ticks_i),
        .high_ticks_i (high_ticks_i),
        .index_o      (index_o)
    );

    task automatic chk(input logic exp, input string tag, input int n);
        checks++;
        if (index_o !== exp) begin
            errs++;
            $display("FAIL %s at cycle %0d: index_o=%0b expected %0b", tag, n, index_o, exp);
        end
    endtask

    task automatic idle(input int k);
        for (int i = 0; i < k; i++) @(negedge clk);
    endtask

    // Sweep of counts and pause polarity with the event input never paused.
    task automatic run_sweep(input int l, input int h, input logic pol);
        int le, he, t_on, t_off;
        le = (l == 0) ? 1 : l;
        he = (h == 0) ? 1 : h;
        t_on  = 3 + le * DIV;
        t_off = 3 + (le + he) * DIV;
        low_ticks_i  = CW'(l);
        high_ticks_i = CW'(h);
        pause_lvl_i  = pol;
        event_i      = ~pol;
        idle(4);
        chk(1'b0, "R1", 0);
        req_i = 1'b1;
        for (int n = 1; n <= t_off + 8; n++) begin
            @(negedge clk);
            if (n < t_on)            chk(1'b0, "R6", n);
            else if (n == t_on)      chk(1'b1, pol ? "R4" : "R5", n);
            else if (n == t_off - 1) chk(1'b1, "R2", n);
            else if (n < t_off)      chk(1'b1, "R7", n);
            else                     chk(1'b0, "R10", n);
        end
        req_i = 1'b0;
        idle(4);
    endtask

    // Trigger while paused, release the pause later.
    task automatic run_pause(input logic pol);
        int t_on, t_off;
        low_ticks_i  = 8'd2;
        high_ticks_i = 8'd2;
        pause_lvl_i  = pol;
        event_i      = pol;
        idle(4);
        t_on  = 22 + 2 * DIV;
        t_off = 22 + 4 * DIV;
        req_i = 1'b1;
        for (int n = 1; n <= t_off + 8; n++) begin
            @(negedge clk);
            if (n == 20) event_i = ~pol;
            if (n <= 20)        chk(1'b0, pol ? "R4" : "R3", n);
            else if (n < t_on)  chk(1'b0, "R3", n);
            else if (n < t_off) chk(1'b1, "R3", n);
            else                chk(1'b0, "R10", n);
        end
        req_i = 1'b0;
        idle(4);
    endtask

    initial begin
        idle(3);
        chk(1'b0, "R1", 0);
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            chk(1'b0, "R1", i);
        end

        for (int p = 0; p < 2; p++)
            for (int l = 0; l < 4; l++)
                for (int h = 0; h < 4; h++)
                    run_sweep(l, h, p[0]);

        run_pause(1'b1);
        run_pause(1'b0);

        // R8: second edge during the low wait restarts the wait
        low_ticks_i  = 8'd4;
        high_ticks_i = 8'd2;
        pause_lvl_i  = 1'b0;
        event_i      = 1'b1;
        idle(4);
        req_i = 1'b1;
        for (int n = 1; n <= 42; n++) begin
            @(negedge clk);
            if (n == 4) req_i = 1'b0;
            if (n == 6) req_i = 1'b1;
            chk((n >= 9 + 4 * DIV && n < 9 + 6 * DIV) ? 1'b1 : 1'b0, "R8", n);
        end
        req_i = 1'b0;
        idle(4);

        // R9: edge during the high phase is ignored
        low_ticks_i  = 8'd1;
        high_ticks_i = 8'd6;
        idle(2);
        req_i = 1'b1;
        for (int n = 1; n <= 60; n++) begin
            @(negedge clk);
            if (n == 10) req_i = 1'b0;
            if (n == 14) req_i = 1'b1;
            chk((n >= 3 + DIV && n < 3 + 7 * DIV) ? 1'b1 : 1'b0, "R9", n);
        end
        req_i = 1'b0;
        idle(2);

        $display("Simulation finished: %0d checks, %0d errors", checks, errs);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errs++;
        $display("FAIL watchdog: run did not finish, actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errs);
        $finish;
    end

endmodule